// File: doc/BRIEF.md
# Eight-Queue Dual-Clock FIFO with Almost-Empty Status Bus

This block holds eight independent logical FIFO queues of 18-bit words in one shared storage array. A write clock domain and a read clock domain run independently. Each side chooses the queue it works on by pulsing a select strobe with a 3-bit queue number. The choice takes hold one clock later on that side, so an operation issued in the same cycle as the strobe still acts on the queue that was selected before.

The read side presents data first-word-fall-through. The oldest word of the selected queue sits on the output whenever that queue holds data, and a read enable only removes it. An active-low almost-empty flag follows the queue selected for reading. An 8-bit active-low status bus shows the almost-empty state of every queue at once, and it is registered one read clock behind the flag logic.

Each queue owns an equal fixed slice of the storage. Its write and read pointers cross between the clock domains as Gray codes through two-stage synchronizers. A write therefore shows up on the read side a few read clocks later. Reads from an empty queue and writes to a full queue are dropped.

Top module: `mq_fifo`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high on both clocks, every queue is emptied. After reset, `rd_avail` is 0, `rd_ae_n` is 0, `ae_bus_n` is all zeros and `wr_full` is 0.
- R2: Some read clocks after words are written into the queue selected for reading, `dout` shows the oldest unread word and `rd_avail` is 1, with no read enable needed first.
- R3: Each read (`ren_n` low while `rd_avail` is 1) removes the shown word. Words leave a queue in the order they were written.
- R4: Words written to one queue never appear when a different queue is selected for reading.
- R5: A write enabled in the same write clock as a `wsel_stb` pulse goes to the previously selected queue. Writes go to queue `wsel_q` from the next write clock on.
- R6: A read enabled in the same read clock as a `rsel_stb` pulse removes a word from the previously selected queue. From the next read clock, `dout` shows the head of queue `rsel_q`.
- R7: `rd_ae_n` is 0 exactly when the queue selected for reading holds no more than `AE_OFF` words (default 8), as seen from the read side. A read that brings the count down to `AE_OFF` drives it low right after that read's clock edge.
- R8: Bit n of `ae_bus_n` is the active-low almost-empty state of queue n, taken one read clock earlier.
- R9: A read enable while `rd_avail` is 0 is ignored. The first word written to that queue afterwards is the first one read out.
- R10: `wr_full` is 1 when the queue selected for writing holds `DEPTH` words (default 16). A write while full is discarded, and it stays discarded after the queue is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wsel_stb | input | 1 | Write queue select strobe |
| wsel_q | input | 3 | Queue number captured by `wsel_stb` |
| wen_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data |
| wr_full | output | 1 | Queue selected for writing is full |
| rsel_stb | input | 1 | Read queue select strobe |
| rsel_q | input | 3 | Queue number captured by `rsel_stb` |
| ren_n | input | 1 | Active-low read enable |
| dout | output | 18 | Head word of the queue selected for reading |
| rd_avail | output | 1 | Queue selected for reading holds a word |
| rd_ae_n | output | 1 | Active-low almost-empty flag of the queue selected for reading |
| ae_bus_n | output | 8 | Active-low almost-empty state of all queues, bit n for queue n |

## Verification
The properties assume that `rst` is high from time zero long enough to cover the first edges of both clocks. They also assume that select strobes are single-cycle pulses driven between edges of their own clock. The stimulus changes inputs only on the falling edge of the clock that owns them. It waits several read clocks after each write burst before it relies on read-side state, so no check depends on exactly when a Gray pointer crosses between the domains.

// File: rtl/mq_pkg.sv
package mq_pkg;

    localparam int NQ = 8;
    localparam int QW = $clog2(NQ);
    localparam int DW = 18;

    typedef logic [DW-1:0] word_t;
    typedef logic [QW-1:0] qid_t;

    typedef struct packed {
        logic stb;
        qid_t q;
    } qsel_t;

endpackage

// File: rtl/mq_sync.sv
module mq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mq_wr_port.sv
module mq_wr_port
    import mq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic                   wclk,
    input  logic                   rst,
    input  qsel_t                  sel,
    input  logic                   wen_n,
    input  logic [NQ-1:0][PW-1:0]  rgray_s,
    output logic [NQ-1:0][PW-1:0]  wgray,
    output logic                   push,
    output logic [QW+AW-1:0]       waddr,
    output logic                   full,
    output qid_t                   wq
);
    logic [NQ-1:0][PW-1:0] wbin;
    logic [PW-1:0]         rbin_cur;
    logic [PW-1:0]         nxt;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rbin_cur = g2b(rgray_s[wq]);
        full     = (wbin[wq] - rbin_cur) == PW'(DEPTH);
        push     = !wen_n && !full;
        nxt      = wbin[wq] + PW'(1);
        waddr    = {wq, wbin[wq][AW-1:0]};
    end

    always_ff @(posedge wclk) begin
        if (rst) begin
            wq    <= '0;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            if (sel.stb) wq <= sel.q;
            if (push) begin
                wbin[wq]  <= nxt;
                wgray[wq] <= nxt ^ (nxt >> 1);
            end
        end
    end
endmodule

// File: rtl/mq_rd_port.sv
module mq_rd_port
    import mq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AE_OFF = 8,
    parameter int AW     = $clog2(DEPTH),
    parameter int PW     = AW + 1
) (
    input  logic                   rclk,
    input  logic                   rst,
    input  qsel_t                  sel,
    input  logic                   ren_n,
    input  logic [NQ-1:0][PW-1:0]  wgray_s,
    output logic [NQ-1:0][PW-1:0]  rgray,
    output logic                   pop,
    output logic [QW+AW-1:0]       raddr,
    output logic                   avail,
    output logic                   ae_n,
    output logic [NQ-1:0]          ae_bus_n,
    output qid_t                   rq
);
    logic [NQ-1:0][PW-1:0] rbin;
    logic [NQ-1:0][PW-1:0] cnt;
    logic [NQ-1:0]         almost;
    logic [PW-1:0]         nxt;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            cnt[q]    = g2b(wgray_s[q]) - rbin[q];
            almost[q] = cnt[q] <= PW'(AE_OFF);
        end
        avail = cnt[rq] != '0;
        ae_n  = !almost[rq];
        pop   = !ren_n && avail;
        nxt   = rbin[rq] + PW'(1);
        raddr = {rq, rbin[rq][AW-1:0]};
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rq       <= '0;
            rbin     <= '0;
            rgray    <= '0;
            ae_bus_n <= '0;
        end else begin
            if (sel.stb) rq <= sel.q;
            if (pop) begin
                rbin[rq]  <= nxt;
                rgray[rq] <= nxt ^ (nxt >> 1);
            end
            ae_bus_n <= ~almost;
        end
    end
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
    import mq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AE_OFF = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wsel_stb,
    input  logic [2:0]    wsel_q,
    input  logic          wen_n,
    input  logic [17:0]   din,
    output logic          wr_full,
    input  logic          rsel_stb,
    input  logic [2:0]    rsel_q,
    input  logic          ren_n,
    output logic [17:0]   dout,
    output logic          rd_avail,
    output logic          rd_ae_n,
    output logic [7:0]    ae_bus_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    qsel_t                 wsel, rsel;
    logic [NQ-1:0][PW-1:0] wgray, wgray_s, rgray, rgray_s;
    logic                  wr_push, rd_pop;
    logic [QW+AW-1:0]      waddr, raddr;
    qid_t                  wq_cur, rq_cur;
    word_t                 mem [NQ*DEPTH];

    assign wsel = '{stb: wsel_stb, q: wsel_q};
    assign rsel = '{stb: rsel_stb, q: rsel_q};

    mq_wr_port #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wclk    (wclk),
        .rst     (rst),
        .sel     (wsel),
        .wen_n   (wen_n),
        .rgray_s (rgray_s),
        .wgray   (wgray),
        .push    (wr_push),
        .waddr   (waddr),
        .full    (wr_full),
        .wq      (wq_cur)
    );

    mq_rd_port #(.DEPTH(DEPTH), .AE_OFF(AE_OFF), .AW(AW), .PW(PW)) u_rd (
        .rclk     (rclk),
        .rst      (rst),
        .sel      (rsel),
        .ren_n    (ren_n),
        .wgray_s  (wgray_s),
        .rgray    (rgray),
        .pop      (rd_pop),
        .raddr    (raddr),
        .avail    (rd_avail),
        .ae_n     (rd_ae_n),
        .ae_bus_n (ae_bus_n),
        .rq       (rq_cur)
    );

    mq_sync #(.W(NQ*PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    mq_sync #(.W(NQ*PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    always_ff @(posedge wclk) begin
        if (wr_push) mem[waddr] <= din;
    end

    assign dout = mem[raddr];
endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk (
    input logic       wclk,
    input logic       rclk,
    input logic       rst,
    input logic       wsel_stb,
    input logic [2:0] wsel_q,
    input logic       rsel_stb,
    input logic [2:0] rsel_q,
    input logic       rd_avail,
    input logic       rd_ae_n,
    input logic [7:0] ae_bus_n,
    input logic [2:0] rq_cur,
    input logic [2:0] wq_cur
);
    // R1: state seen right after reset
    a_r1_reset_state: assert property (@(posedge rclk) disable iff (rst)
        $past(rst) |-> (!rd_avail && ae_bus_n == 8'h00));

    // R5: write selection lands one write clock after the strobe
    a_r5_wsel_late: assert property (@(posedge wclk) disable iff (rst)
        wsel_stb |=> wq_cur == $past(wsel_q));

    // R6: read selection lands one read clock after the strobe
    a_r6_rsel_late: assert property (@(posedge rclk) disable iff (rst)
        rsel_stb |=> rq_cur == $past(rsel_q));

    // R7: an empty selected queue is always almost empty
    a_r7_empty_is_ae: assert property (@(posedge rclk) disable iff (rst)
        !rd_avail |-> !rd_ae_n);

    // R8: bus bit of the selected queue trails the discrete flag by one clock
    a_r8_bus_lag: assert property (@(posedge rclk) disable iff (rst)
        !$past(rst) |-> ae_bus_n[$past(rq_cur)] == $past(rd_ae_n));
endmodule

bind mq_fifo mq_fifo_chk u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst      (rst),
    .wsel_stb (wsel_stb),
    .wsel_q   (wsel_q),
    .rsel_stb (rsel_stb),
    .rsel_q   (rsel_q),
    .rd_avail (rd_avail),
    .rd_ae_n  (rd_ae_n),
    .ae_bus_n (ae_bus_n),
    .rq_cur   (rq_cur),
    .wq_cur   (wq_cur)
);

// File: tb/mq_fifo_test.sv
module mq_fifo_test;
    logic        wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic        wsel_stb = 1'b0, rsel_stb = 1'b0, wen_n = 1'b1, ren_n = 1'b1;
    logic [2:0]  wsel_q = '0, rsel_q = '0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        wr_full, rd_avail, rd_ae_n;
    logic [7:0]  ae_bus_n;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #4 wclk = ~wclk;
    always #5 rclk = ~rclk;

    mq_fifo uut (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wsel_stb(wsel_stb), .wsel_q(wsel_q), .wen_n(wen_n), .din(din), .wr_full(wr_full),
        .rsel_stb(rsel_stb), .rsel_q(rsel_q), .ren_n(ren_n), .dout(dout),
        .rd_avail(rd_avail), .rd_ae_n(rd_ae_n), .ae_bus_n(ae_bus_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wsel(input logic [2:0] q);
        @(negedge wclk); wsel_stb = 1'b1; wsel_q = q;
        @(negedge wclk); wsel_stb = 1'b0;
    endtask

    task automatic wr(input logic [17:0] d);
        @(negedge wclk); wen_n = 1'b0; din = d;
        @(negedge wclk); wen_n = 1'b1;
    endtask

    task automatic rsel(input logic [2:0] q);
        @(negedge rclk); rsel_stb = 1'b1; rsel_q = q;
        @(negedge rclk); rsel_stb = 1'b0;
    endtask

    task automatic rd();
        @(negedge rclk); ren_n = 1'b0;
        @(negedge rclk); ren_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic t_reset();
        settle();
        chk("R1 rd_avail", 32'(rd_avail), 0);
        chk("R1 rd_ae_n", 32'(rd_ae_n), 0);
        chk("R1 ae_bus_n", 32'(ae_bus_n), 0);
        chk("R1 wr_full", 32'(wr_full), 0);
    endtask

    task automatic t_fwft_order();
        wsel(3'd1);
        wr(18'h00101); wr(18'h00102); wr(18'h00103);
        rsel(3'd1); settle();
        chk("R2 avail before read", 32'(rd_avail), 1);
        chk("R2 head shown", 32'(dout), 32'h101);
        rd(); chk("R3 second word", 32'(dout), 32'h102);
        rd(); chk("R3 third word", 32'(dout), 32'h103);
        rd(); chk("R3 drained", 32'(rd_avail), 0);
    endtask

    task automatic t_independent();
        wsel(3'd2); wr(18'h00201);
        wsel(3'd3); wr(18'h00301); wr(18'h00302);
        rsel(3'd2); settle();
        chk("R4 q2 head", 32'(dout), 32'h201);
        rd(); chk("R4 q2 empty after one", 32'(rd_avail), 0);
        rsel(3'd3); settle();
        chk("R4 q3 head", 32'(dout), 32'h301);
        rd(); rd();
        chk("R4 q3 drained", 32'(rd_avail), 0);
    endtask

    task automatic t_select_pipeline();
        wsel(3'd4);
        @(negedge wclk); wsel_stb = 1'b1; wsel_q = 3'd5; wen_n = 1'b0; din = 18'h0004A;
        @(negedge wclk); wsel_stb = 1'b0; din = 18'h0005B;
        @(negedge wclk); wen_n = 1'b1;
        wsel(3'd4); wr(18'h0004C);
        rsel(3'd4); settle();
        chk("R5 strobe-cycle write in old queue", 32'(dout), 32'h4A);
        @(negedge rclk); rsel_stb = 1'b1; rsel_q = 3'd5; ren_n = 1'b0;
        @(negedge rclk); rsel_stb = 1'b0; ren_n = 1'b1;
        chk("R6 new queue head next cycle", 32'(dout), 32'h5B);
        chk("R5 following write in new queue", 32'(rd_avail), 1);
        rd();
        chk("R5 new queue holds one", 32'(rd_avail), 0);
        rsel(3'd4);
        chk("R6 strobe-cycle read popped old queue", 32'(dout), 32'h4C);
        rd();
    endtask

    task automatic t_empty_read();
        rsel(3'd6); settle();
        chk("R9 empty", 32'(rd_avail), 0);
        rd(); rd();
        chk("R9 still empty", 32'(rd_avail), 0);
        wsel(3'd6); wr(18'h00601); settle();
        chk("R9 avail after write", 32'(rd_avail), 1);
        chk("R9 first word intact", 32'(dout), 32'h601);
        rd();
        chk("R9 drained", 32'(rd_avail), 0);
    endtask

    task automatic t_almost_empty();
        wsel(3'd7);
        for (int i = 0; i < 9; i++) wr(18'(32'h700 + i));
        rsel(3'd7); settle();
        chk("R7 nine words not almost empty", 32'(rd_ae_n), 1);
        chk("R8 bus bit7 high", 32'(ae_bus_n[7]), 1);
        chk("R8 bus bit0 low (q0 empty)", 32'(ae_bus_n[0]), 0);
        rd();
        chk("R7 flag low right after read", 32'(rd_ae_n), 0);
        chk("R8 bus still old value", 32'(ae_bus_n[7]), 1);
        @(negedge rclk);
        chk("R8 bus follows one clock later", 32'(ae_bus_n[7]), 0);
        for (int i = 1; i < 9; i++) begin
            chk("R3 q7 order", 32'(dout), 32'h700 + 32'(i));
            rd();
        end
        chk("R7 drained", 32'(rd_avail), 0);
    endtask

    task automatic t_full();
        wsel(3'd0);
        for (int i = 0; i < 16; i++) wr(18'(32'h3000 + i));
        chk("R10 full at depth", 32'(wr_full), 1);
        wr(18'h3FFFF);
        rsel(3'd0); settle();
        for (int i = 0; i < 16; i++) begin
            chk("R10 stored word", 32'(dout), 32'h3000 + 32'(i));
            rd();
        end
        chk("R10 extra write dropped", 32'(rd_avail), 0);
        repeat (8) @(negedge wclk);
        chk("R10 not full after drain", 32'(wr_full), 0);
    endtask

    initial begin
        repeat (6) @(negedge rclk);
        rst = 1'b0;
        t_reset();
        t_fwft_order();
        t_independent();
        t_select_pipeline();
        t_empty_read();
        t_almost_empty();
        t_full();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule